// File: doc/BRIEF.md
# Multi-source reset distribution controller

This block gathers every reset request of a multicore chip and turns them into one active-low reset per logic domain. Two requests arrive on raw active-low pins (power-on and warm). Three on-chip sources raise system reset: a debug emulator, a serial link and a watchdog. Each core can also be reset on its own. Each reset type clears a different set of domains, from power-on (everything) down to core-local (one core). Pin resets take hold at once, without a clock. They are released through a two-flop synchronizer. Every domain output is then kept low for a fixed stretch after its last active request.

The controller also drives the main PLL control. It holds the PLL disabled and in bypass after power-on, and it leaves bypass once lock is reported. It gives a one-cycle strobe to the configuration latches when those latches come out of reset. A one-hot cause register records the most recent reset type that was not absorbed by a wider one. Software clears its bits by writing one.

Top module: `rstc_top`

## Requirements
- R1: While `por_n` is low, every domain output, every core output and `cfg_strobe` is low at once, without waiting for a clock. `rst_test_n`, `rst_pll2_n` and `rst_frame_n` are driven low by power-on only.
- R2: A low level on `warm_n` drives `rst_chip_n`, `rst_mem_n`, `rst_cfg_n`, `rst_periph_n` and all `rst_core_n` low at once. `rst_test_n`, `rst_pll2_n` and `rst_frame_n` stay high.
- R3: A high bit in `sys_req` (bit 0 emulator, bit 1 serial link, bit 2 watchdog) is sampled on the clock. It drives `rst_chip_n` and all `rst_core_n` low. It leaves `rst_mem_n`, `rst_cfg_n`, `rst_periph_n`, `rst_test_n`, `rst_pll2_n` and `rst_frame_n` high.
- R4: A high `core_req[i]` drives only `rst_core_n[i]` low. Every other output is unaffected.
- R5: The pins pass through two flops before release. With the default HOLD of 16, an output freed by a pin rise goes high at the 19th clock edge after that rise. An output freed by a clocked request goes high at the 17th edge after the last edge that sampled the request high.
- R6: When requests overlap, each output stays low until the latest of its requests has run out its stretch. A narrower request that falls inside a wider reset gives no second low pulse.
- R7: `cfg_strobe` is high for exactly the one cycle after `rst_cfg_n` rises. Only power-on and warm reset can cause it, so system and core-local resets never produce it.
- R8: During power-on reset `pll_en` is 0 and `pll_bypass` is 1. `pll_en` goes high at the edge after `rst_test_n` is sampled high. `pll_bypass` goes low at the edge after `pll_en` and `pll_lock` are both sampled high. Warm, system and core-local resets do not change either signal.
- R9: `cause` is one-hot: bit 0 power-on, bit 1 warm, bit 2 system, bit 3 core-local. Power-on sets 0001. A new warm, system or core request sets its own bit alone, but only if it is not absorbed. It is absorbed if a wider reset already holds its outputs at the edge where it starts.
- R10: At an edge with no new event, each bit set in `cause_clr` clears the matching `cause` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Raw power-on request pin, active low |
| warm_n | input | 1 | Raw warm reset request pin, active low |
| sys_req | input | 3 | System reset requests: emulator, serial link, watchdog |
| core_req | input | NCORE | Per-core local reset requests |
| pll_lock | input | 1 | Main PLL lock indication |
| cause_clr | input | 4 | Write-one-to-clear strobes for the cause bits |
| rst_test_n | output | 1 | Test and emulation logic reset |
| rst_pll2_n | output | 1 | Secondary PLL domain reset |
| rst_frame_n | output | 1 | Antenna and frame-sync logic reset |
| rst_chip_n | output | 1 | General chip logic reset |
| rst_mem_n | output | 1 | Memory contents reset |
| rst_cfg_n | output | 1 | Configuration latch reset |
| rst_periph_n | output | 1 | Peripheral enable state reset |
| rst_core_n | output | NCORE | Per-core reset |
| pll_en | output | 1 | Main PLL enable |
| pll_bypass | output | 1 | Main PLL bypass select |
| cfg_strobe | output | 1 | One-cycle configuration sample strobe |
| cause | output | 4 | One-hot type of the most recent reset |

## Verification
The bench targets overlaps. It sends a core request inside a system reset, a system request inside the tail of a warm stretch, and a warm pulse during a core stretch. A design without absorption would show a second pulse or record the wrong cause. A design that restarts the stretch from the wrong source would release too early or too late. The bench also checks the exact release edge after each pin rise, so a missing or extra synchronizer stage shows up as a one-edge shift. It checks that system resets give no configuration strobe and leave memory untouched, which catches wrong domain masks. The bench raises PLL lock both before and after power-on release to pin down when bypass is dropped.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  // domain indices inside the controller's domain vector
  localparam int D_TEST  = 0;
  localparam int D_PLL2  = 1;
  localparam int D_FRAME = 2;
  localparam int D_CHIP  = 3;
  localparam int D_MEM   = 4;
  localparam int D_CFG   = 5;
  localparam int D_PERI  = 6;
  localparam int D_CORE0 = 7;

  // cause register bit positions
  localparam int CB_POR  = 0;
  localparam int CB_WARM = 1;
  localparam int CB_SYS  = 2;
  localparam int CB_CORE = 3;
  localparam int NCAUSE  = 4;

  typedef logic [NCAUSE-1:0] cause_t;

  function automatic cause_t cause_onehot(input int bitpos);
    cause_t v;
    v = '0;
    v[bitpos] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync (
  input  logic clk,
  input  logic pin_n,
  output logic act
);
  logic s1, s2;

  always_ff @(posedge clk or negedge pin_n) begin
    if (!pin_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= 1'b1;
      s2 <= s1;
    end
  end

  assign act = ~s2;
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic rst_n
);
  localparam int CW = $clog2(HOLD + 2);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] cnt;

  // counter step: reload on a request, run down otherwise
  function automatic logic [CW-1:0] count_next(input logic r, input logic [CW-1:0] c);
    if (r) return HOLD_V;
    if (c != '0) return c - 1'b1;
    return '0;
  endfunction

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt   <= HOLD_V;
      rst_n <= 1'b0;
    end else begin
      cnt   <= count_next(req, cnt);
      rst_n <= !(req || cnt != '0);
    end
  end
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause #(
  parameter int NCORE = 3
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  por_act,
  input  logic                  warm_act,
  input  logic                  sys_act,
  input  logic [NCORE-1:0]      core_req,
  input  logic                  test_free,
  input  logic                  chip_free,
  input  logic [NCORE-1:0]      core_free,
  input  rstc_pkg::cause_t      clr,
  output rstc_pkg::cause_t      cause
);
  import rstc_pkg::*;

  logic             warm_prev, sys_prev;
  logic [NCORE-1:0] core_prev;
  logic             ev_warm, ev_sys, ev_core;

  // an event counts only when no wider reset already holds its outputs
  assign ev_warm = warm_act & ~warm_prev & test_free;
  assign ev_sys  = sys_act & ~sys_prev & chip_free;
  assign ev_core = (|(core_req & ~core_prev & core_free)) & ~sys_act;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      warm_prev <= 1'b0;
      sys_prev  <= 1'b0;
      core_prev <= '0;
      cause     <= cause_onehot(CB_POR);
    end else begin
      warm_prev <= warm_act;
      sys_prev  <= sys_act;
      core_prev <= core_req;
      if (por_act)      cause <= cause_onehot(CB_POR);
      else if (ev_warm) cause <= cause_onehot(CB_WARM);
      else if (ev_sys)  cause <= cause_onehot(CB_SYS);
      else if (ev_core) cause <= cause_onehot(CB_CORE);
      else              cause <= cause & ~clr;
    end
  end

  // R9
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(cause));
endmodule

// File: rtl/rstc_top.sv
module rstc_top #(
  parameter int NCORE = 3,
  parameter int HOLD  = 16
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   warm_n,
  input  logic [2:0]             sys_req,
  input  logic [NCORE-1:0]       core_req,
  input  logic                   pll_lock,
  input  logic [3:0]             cause_clr,
  output logic                   rst_test_n,
  output logic                   rst_pll2_n,
  output logic                   rst_frame_n,
  output logic                   rst_chip_n,
  output logic                   rst_mem_n,
  output logic                   rst_cfg_n,
  output logic                   rst_periph_n,
  output logic [NCORE-1:0]       rst_core_n,
  output logic                   pll_en,
  output logic                   pll_bypass,
  output logic                   cfg_strobe,
  output logic [3:0]             cause
);
  import rstc_pkg::*;

  localparam int ND = D_CORE0 + NCORE;

  logic por_act, warm_act, sys_act, arst_wide_n;
  logic [ND-1:0] dom_req, dom_arst_n, dom_rst_n;
  logic cfg_prev;

  rstc_sync u_por_sync  (.clk(clk), .pin_n(por_n),  .act(por_act));
  rstc_sync u_warm_sync (.clk(clk), .pin_n(warm_n), .act(warm_act));

  assign sys_act     = |sys_req;
  assign arst_wide_n = por_n & warm_n;

  // domain request map: which reset types reach which domain
  always_comb begin
    dom_req[D_TEST]     = por_act;
    dom_req[D_PLL2]     = por_act;
    dom_req[D_FRAME]    = por_act;
    dom_req[D_MEM]      = por_act | warm_act;
    dom_req[D_CFG]      = por_act | warm_act;
    dom_req[D_PERI]     = por_act | warm_act;
    dom_req[D_CHIP]     = por_act | warm_act | sys_act;
    dom_arst_n          = {ND{arst_wide_n}};
    dom_arst_n[D_TEST]  = por_n;
    dom_arst_n[D_PLL2]  = por_n;
    dom_arst_n[D_FRAME] = por_n;
    for (int i = 0; i < NCORE; i++)
      dom_req[D_CORE0+i] = por_act | warm_act | sys_act | core_req[i];
  end

  for (genvar g = 0; g < ND; g++) begin : g_dom
    rstc_stretch #(.HOLD(HOLD)) u_str (
      .clk(clk), .arst_n(dom_arst_n[g]), .req(dom_req[g]), .rst_n(dom_rst_n[g]));
  end

  assign rst_test_n   = dom_rst_n[D_TEST];
  assign rst_pll2_n   = dom_rst_n[D_PLL2];
  assign rst_frame_n  = dom_rst_n[D_FRAME];
  assign rst_chip_n   = dom_rst_n[D_CHIP];
  assign rst_mem_n    = dom_rst_n[D_MEM];
  assign rst_cfg_n    = dom_rst_n[D_CFG];
  assign rst_periph_n = dom_rst_n[D_PERI];
  assign rst_core_n   = dom_rst_n[D_CORE0 +: NCORE];

  // configuration sample strobe on release of the latch domain
  always_ff @(posedge clk or negedge dom_arst_n[D_CFG]) begin
    if (!dom_arst_n[D_CFG]) cfg_prev <= 1'b0;
    else                    cfg_prev <= rst_cfg_n;
  end
  assign cfg_strobe = rst_cfg_n & ~cfg_prev;

  // main PLL control: disabled and bypassed through power-on only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pll_en     <= 1'b0;
      pll_bypass <= 1'b1;
    end else begin
      pll_en <= rst_test_n;
      if (!rst_test_n)            pll_bypass <= 1'b1;
      else if (pll_en && pll_lock) pll_bypass <= 1'b0;
    end
  end

  rstc_cause #(.NCORE(NCORE)) u_cause (
    .clk(clk), .por_n(por_n), .por_act(por_act), .warm_act(warm_act),
    .sys_act(sys_act), .core_req(core_req), .test_free(rst_test_n),
    .chip_free(rst_chip_n), .core_free(rst_core_n), .clr(cause_clr),
    .cause(cause));

  // R1
  por_holds_all_chk: assert property (@(posedge clk) disable iff (!por_n)
    por_act |-> (!rst_test_n && !rst_chip_n && !rst_mem_n));
  // R3
  sys_spares_mem_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (rst_mem_n && !warm_act && !por_act) |=> rst_mem_n);
  // R4
  core_spares_chip_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    (rst_chip_n && !sys_act && !warm_act && !por_act) |=> rst_chip_n);
  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!por_n || !warm_n)
    cfg_strobe |=> !cfg_strobe);
  // R8
  pll_bypass_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_test_n |-> (pll_bypass && !pll_en));
endmodule

// File: tb/rstc_top_tb_top.sv
module rstc_top_tb_top;
  localparam int NC   = 3;
  localparam int HOLD = 16;
  localparam int ND   = 7 + NC;

  logic clk = 1'b0;
  logic por_n, warm_n, pll_lock;
  logic [2:0] sys_req;
  logic [NC-1:0] core_req;
  logic [3:0] cause_clr;
  logic rst_test_n, rst_pll2_n, rst_frame_n, rst_chip_n, rst_mem_n, rst_cfg_n, rst_periph_n;
  logic [NC-1:0] rst_core_n;
  logic pll_en, pll_bypass, cfg_strobe;
  logic [3:0] cause;

  always #5 clk = ~clk;

  rstc_top #(.NCORE(NC), .HOLD(HOLD)) dut_i (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .sys_req(sys_req), .core_req(core_req),
    .pll_lock(pll_lock), .cause_clr(cause_clr), .rst_test_n(rst_test_n),
    .rst_pll2_n(rst_pll2_n), .rst_frame_n(rst_frame_n), .rst_chip_n(rst_chip_n),
    .rst_mem_n(rst_mem_n), .rst_cfg_n(rst_cfg_n), .rst_periph_n(rst_periph_n),
    .rst_core_n(rst_core_n), .pll_en(pll_en), .pll_bypass(pll_bypass),
    .cfg_strobe(cfg_strobe), .cause(cause));

  int n_chk = 0, n_fail = 0;
  string phase = "R1";
  bit checking = 0, done = 0;

  // reference model state
  int pin_por_edges = 0, pin_warm_edges = 0;
  int quiet [ND];
  bit m_en = 0, m_byp = 1, m_cfg_prev = 0, m_wprev = 0, m_sprev = 0;
  bit [NC-1:0] m_cprev = '0;
  bit [3:0] m_cause = 4'b0001;

  initial for (int d = 0; d < ND; d++) quiet[d] = 0;

  // domains 0..2 are cleared by power-on only; 3 chip, 4 mem, 5 cfg, 6 periph, 7.. cores
  function automatic bit exp_dom(int d);
    bit pin_ok;
    pin_ok = (d <= 2) ? por_n : (por_n && warm_n);
    return pin_ok && (quiet[d] > HOLD);
  endfunction

  always @(posedge clk) begin
    bit pr, wr, sr, e_test, e_chip, nb, ew, es, ec;
    bit [NC-1:0] e_core;
    bit [ND-1:0] rq;
    pr = !por_n || pin_por_edges < 2;
    wr = !warm_n || pin_warm_edges < 2;
    sr = |sys_req;
    e_test = exp_dom(0);
    e_chip = exp_dom(3);
    for (int i = 0; i < NC; i++) e_core[i] = exp_dom(7 + i);
    m_cfg_prev = exp_dom(5);
    rq[0] = pr; rq[1] = pr; rq[2] = pr;
    rq[4] = pr || wr; rq[5] = pr || wr; rq[6] = pr || wr;
    rq[3] = pr || wr || sr;
    for (int i = 0; i < NC; i++) rq[7 + i] = pr || wr || sr || core_req[i];
    for (int d = 0; d < ND; d++) quiet[d] = rq[d] ? 0 : (quiet[d] < 1000 ? quiet[d] + 1 : quiet[d]);
    if (!por_n) begin
      m_en = 0; m_byp = 1; m_wprev = 0; m_sprev = 0; m_cprev = '0; m_cause = 4'b0001;
    end else begin
      nb = !e_test ? 1'b1 : ((m_en && pll_lock) ? 1'b0 : m_byp);
      m_en = e_test; m_byp = nb;
      ew = wr && !m_wprev && e_test;
      es = sr && !m_sprev && e_chip;
      ec = (|(core_req & ~m_cprev & e_core)) && !sr;
      if (pr)      m_cause = 4'b0001;
      else if (ew) m_cause = 4'b0010;
      else if (es) m_cause = 4'b0100;
      else if (ec) m_cause = 4'b1000;
      else         m_cause = m_cause & ~cause_clr;
      m_wprev = wr; m_sprev = sr; m_cprev = core_req;
    end
    pin_por_edges  = por_n  ? (pin_por_edges  < 1000 ? pin_por_edges  + 1 : pin_por_edges)  : 0;
    pin_warm_edges = warm_n ? (pin_warm_edges < 1000 ? pin_warm_edges + 1 : pin_warm_edges) : 0;
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (phase %s) %s actual=%0h expected=%0h at %0t", tag, phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking && !done) begin
    bit [NC-1:0] ec;
    for (int i = 0; i < NC; i++) ec[i] = exp_dom(7 + i);
    chk("R1", "rst_test_n",   32'(rst_test_n),   32'(exp_dom(0)));
    chk("R1", "rst_pll2_n",   32'(rst_pll2_n),   32'(exp_dom(1)));
    chk("R1", "rst_frame_n",  32'(rst_frame_n),  32'(exp_dom(2)));
    chk("R3", "rst_chip_n",   32'(rst_chip_n),   32'(exp_dom(3)));
    chk("R2", "rst_mem_n",    32'(rst_mem_n),    32'(exp_dom(4)));
    chk("R2", "rst_cfg_n",    32'(rst_cfg_n),    32'(exp_dom(5)));
    chk("R2", "rst_periph_n", 32'(rst_periph_n), 32'(exp_dom(6)));
    chk("R4", "rst_core_n",   32'(rst_core_n),   32'(ec));
    chk("R7", "cfg_strobe",   32'(cfg_strobe),   32'(exp_dom(5) && !m_cfg_prev));
    chk("R8", "pll_en",       32'(pll_en),       32'(por_n ? m_en : 1'b0));
    chk("R8", "pll_bypass",   32'(pll_bypass),   32'(por_n ? m_byp : 1'b1));
    chk("R9", "cause",        32'(cause),        32'(por_n ? m_cause : 4'b0001));
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    por_n = 1; warm_n = 1; pll_lock = 0; sys_req = '0; core_req = '0; cause_clr = '0;
    #1 por_n = 0; checking = 1;
    // R1 power-on, R5 release timing, R8 PLL with late lock
    phase = "R1"; cyc(4);
    phase = "R5"; por_n = 1; cyc(40);
    phase = "R8"; pll_lock = 1; cyc(5);
    // R10 clear the power-on cause
    phase = "R10"; cause_clr = 4'b0001; cyc(1); cause_clr = '0; cyc(2);
    // R2 warm reset
    phase = "R2"; warm_n = 0; cyc(3); warm_n = 1; cyc(30);
    // R3 system reset from emulator, then watchdog with an absorbed core request
    phase = "R3"; sys_req = 3'b001; cyc(1); sys_req = '0; cyc(25);
    phase = "R6"; sys_req = 3'b100; cyc(2); core_req = 3'b010; cyc(1); core_req = '0; cyc(2);
    sys_req = '0; cyc(30);
    // R4 core-local resets, one alone then two staggered
    phase = "R4"; core_req = 3'b100; cyc(1); core_req = '0; cyc(25);
    core_req = 3'b001; cyc(3); core_req = 3'b011; cyc(1); core_req = '0; cyc(25);
    // R6 warm pulse during a core stretch
    phase = "R6"; core_req = 3'b001; cyc(1); core_req = '0; cyc(3);
    warm_n = 0; cyc(2); warm_n = 1; cyc(5);
    // R6 serial-link request in the warm tail is absorbed
    sys_req = 3'b010; cyc(1); sys_req = '0; cyc(30);
    // R5 back-to-back system requests extend the stretch
    phase = "R5"; sys_req = 3'b001; cyc(1); sys_req = '0; cyc(10);
    sys_req = 3'b100; cyc(1); sys_req = '0; cyc(30);
    // R10 clear with a mask that misses, then hits
    phase = "R10"; cause_clr = 4'b0011; cyc(1); cause_clr = 4'b0100; cyc(1); cause_clr = '0; cyc(2);
    // R1 power-on during a warm reset, lock already high
    phase = "R1"; warm_n = 0; cyc(2); por_n = 0; cyc(3); warm_n = 1; cyc(2); por_n = 1; cyc(45);
    // R8 system reset after lock leaves PLL alone
    phase = "R8"; sys_req = 3'b010; cyc(2); sys_req = '0; cyc(25);
    finish_run();
  end
endmodule